// File: doc/BRIEF.md
# Register-Write to Packet-Stream Transmit Bridge

This block lets an embedded processor send Ethernet frames into a packet stream through three word-wide write registers. Software first stores the frame length. Before each bus word it stores a metadata word that carries a byte-valid mask, an end-of-frame flag and the port masks. It then writes the data word, and that write commits one beat to the stream.

Data words arrive most significant byte first, so the bridge reverses the byte lanes and the first frame byte leaves on lane 0. Each beat goes into a small holding FIFO. The FIFO drives a valid/ready stream with data, keep, last and a 16-bit user sideband.

The bus word width is a parameter, 32 or 64 bits. When the FIFO is full, a data write is stalled through a ready signal and is never dropped. Writes to the metadata and length registers are never stalled.

Top module: `pio_tx_bridge`

## Requirements
- R1: Writes decode on the full address: offset 0x00 is beat data, offset 0x08 is beat metadata and offset 0x10 is frame length, in both word widths.
- R2: A write to the length register makes `frame_len_o` equal to the low 16 bits of the written word from the next cycle on.
- R3: Each accepted data write enqueues exactly one beat. When the FIFO was empty, `tvalid_o` is high in the cycle after the write.
- R4: Stream byte k, `tdata_o[8k+7:8k]`, equals written byte lane NB-1-k, where NB = DATA_W/8. The most significant written byte is therefore the first frame byte.
- R5: A beat carries fields of the last metadata word. `tkeep_o` is metadata bits [NB-1:0]. `tlast_o` is metadata bit 15. `tuser_o` is metadata bits 31:16: destination mask in `tuser_o[15:8]`, source mask in `tuser_o[7:0]`.
- R6: Metadata stays latched across any number of data writes until it is written again. Reset clears it to zero.
- R7: With the FIFO full, `wr_ready_o` is low while a data write is presented. The stalled write completes once a beat drains, and no beat is lost. Metadata and length writes are accepted while the FIFO is full.
- R8: While `tvalid_o` is high and `tready_i` is low, every stream output holds steady. Beats leave in write order.
- R9: Writes to any other address leave the stream, the metadata and the length unchanged.
- R10: Reset, which is asynchronous and active low, empties the FIFO and clears `tvalid_o` and `frame_len_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write request |
| wr_addr_i | input | ADDR_W | Byte offset of the write |
| wr_data_i | input | DATA_W | Write data |
| wr_ready_o | output | 1 | Write accepted this cycle (low = wait) |
| frame_len_o | output | 16 | Latched frame length in bytes |
| tvalid_o | output | 1 | Stream beat valid |
| tready_i | input | 1 | Stream sink ready |
| tdata_o | output | DATA_W | Beat data, lane 0 = first byte |
| tkeep_o | output | DATA_W/8 | Byte valid mask |
| tlast_o | output | 1 | Final beat of frame |
| tuser_o | output | 16 | Destination and source port masks |

## Verification
The assertions check four rules on every cycle:
- an accepted data write is followed by a valid beat;
- a stalled stream holds its outputs;
- an empty FIFO never refuses a write;
- a metadata or unmapped write never creates a beat from an empty FIFO.

They also check that a length write lands in the following cycle. Only the directed scenarios can show:
- the byte-lane reversal against computed values;
- the field mapping;
- metadata persistence across beats and through reset;
- ordering across a full-FIFO stall that carries a metadata change.

// File: rtl/pio_tx_pkg.sv
package pio_tx_pkg;
  localparam int unsigned OFF_DATA  = 'h00;
  localparam int unsigned OFF_META  = 'h08;
  localparam int unsigned OFF_LEN   = 'h10;
  localparam int unsigned META_W    = 32;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned USER_W    = 16;
  localparam int unsigned LAST_BIT  = 15;
  localparam int unsigned PORT_LSB  = 16;
endpackage

// File: rtl/pio_tx_regs.sv
module pio_tx_regs
  import pio_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fifo_full_i,
  output logic              wr_ready_o,
  output logic              push_o,
  output logic [META_W-1:0] meta_o,
  output logic [LEN_W-1:0]  len_o
);
  logic sel_data, sel_meta, sel_len;
  logic unused_hi;

  assign sel_data = (wr_addr_i == ADDR_W'(OFF_DATA));
  assign sel_meta = (wr_addr_i == ADDR_W'(OFF_META));
  assign sel_len  = (wr_addr_i == ADDR_W'(OFF_LEN));

  // only a data write can be held off
  assign wr_ready_o = !(sel_data && fifo_full_i);
  assign push_o     = wr_en_i && sel_data && !fifo_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_o <= '0;
      len_o  <= '0;
    end else if (wr_en_i) begin
      if (sel_meta) meta_o <= wr_data_i[META_W-1:0];
      if (sel_len)  len_o  <= wr_data_i[LEN_W-1:0];
    end
  end

  generate
    if (DATA_W > META_W) begin : g_wide
      assign unused_hi = ^wr_data_i[DATA_W-1:META_W];
    end else begin : g_narrow
      assign unused_hi = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pio_tx_beat_pack.sv
module pio_tx_beat_pack
  import pio_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB      = DATA_W / 8,
  localparam int unsigned ENTRY_W = USER_W + 1 + NB + DATA_W
) (
  input  logic [DATA_W-1:0]  word_i,
  input  logic [META_W-1:0]  meta_i,
  output logic [ENTRY_W-1:0] entry_o
);
  logic [DATA_W-1:0] swapped;
  logic              unused_mid;

  // big-endian bus word: MSB lane is the first frame byte
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign swapped[8*k +: 8] = word_i[8*(NB-1-k) +: 8];
  end

  assign entry_o = {meta_i[PORT_LSB +: USER_W], meta_i[LAST_BIT], meta_i[NB-1:0], swapped};

  generate
    if (LAST_BIT > NB) begin : g_gap
      assign unused_mid = ^meta_i[LAST_BIT-1:NB];
    end else begin : g_nogap
      assign unused_mid = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pio_tx_fifo.sv
module pio_tx_fifo #(
  parameter int unsigned WIDTH = 53,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (do_pop) rp_q <= nxt(rp_q);
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end
endmodule

// File: rtl/pio_tx_bridge.sv
module pio_tx_bridge
  import pio_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned NB        = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic [15:0]       frame_len_o,
  output logic              tvalid_o,
  input  logic              tready_i,
  output logic [DATA_W-1:0] tdata_o,
  output logic [NB-1:0]     tkeep_o,
  output logic              tlast_o,
  output logic [15:0]       tuser_o
);
  localparam int unsigned ENTRY_W = USER_W + 1 + NB + DATA_W;

  logic               push, full, empty;
  logic [META_W-1:0]  meta;
  logic [ENTRY_W-1:0] entry_in, entry_out;

  pio_tx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .fifo_full_i(full), .wr_ready_o, .push_o(push),
    .meta_o(meta), .len_o(frame_len_o)
  );

  pio_tx_beat_pack #(.DATA_W(DATA_W)) u_pack (
    .word_i(wr_data_i), .meta_i(meta), .entry_o(entry_in)
  );

  pio_tx_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .din_i(entry_in),
    .pop_i(tready_i), .dout_o(entry_out), .empty_o(empty), .full_o(full)
  );

  assign tvalid_o = !empty;
  assign {tuser_o, tlast_o, tkeep_o, tdata_o} = entry_out;
endmodule

// File: rtl/pio_tx_bridge_chk.sv
module pio_tx_bridge_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NB    = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wr_ready_o,
  input logic [15:0]       frame_len_o,
  input logic              tvalid_o,
  input logic              tready_i,
  input logic [DATA_W-1:0] tdata_o,
  input logic [NB-1:0]     tkeep_o,
  input logic              tlast_o,
  input logic [15:0]       tuser_o
);
  logic is_data, is_len;
  assign is_data = (wr_addr_i == ADDR_W'('h00));
  assign is_len  = (wr_addr_i == ADDR_W'('h10));

  assert_len_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && is_len |=> frame_len_o == $past(wr_data_i[15:0]));

  assert_push_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_ready_o && is_data |=> tvalid_o);

  assert_empty_never_stalls_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tvalid_o |-> wr_ready_o);

  assert_stall_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_o && !tready_i |=> tvalid_o && $stable(tdata_o) && $stable(tkeep_o)
      && $stable(tlast_o) && $stable(tuser_o));

  assert_nondata_no_beat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tvalid_o && !(wr_en_i && is_data) |=> !tvalid_o);
endmodule

bind pio_tx_bridge pio_tx_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o), .frame_len_o(frame_len_o),
  .tvalid_o(tvalid_o), .tready_i(tready_i), .tdata_o(tdata_o), .tkeep_o(tkeep_o),
  .tlast_o(tlast_o), .tuser_o(tuser_o)
);

// File: tb/sim_pio_tx_bridge.sv
`timescale 1ns/1ps
module sim_pio_tx_bridge;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 4;
  localparam int NB = DW / 8;

  logic          clk = 0, rst_ni = 0;
  logic          wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, tvalid, tlast;
  logic          tready = 0;
  logic [15:0]   frame_len, tuser;
  logic [DW-1:0] tdata;
  logic [NB-1:0] tkeep;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pio_tx_bridge #(.DATA_W(DW), .ADDR_W(AW), .FIFO_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_ready_o(wr_ready), .frame_len_o(frame_len),
    .tvalid_o(tvalid), .tready_i(tready), .tdata_o(tdata), .tkeep_o(tkeep),
    .tlast_o(tlast), .tuser_o(tuser)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] swap(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    for (int k = 0; k < NB; k++) r[8*k +: 8] = w[8*(NB-1-k) +: 8];
    return r;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_en = 0; wr_addr = 8'hFF;
  endtask

  task automatic pop_check(input string req, input logic [DW-1:0] word, input logic [31:0] meta);
    @(negedge clk);
    while (!tvalid) @(negedge clk);
    check(tdata == swap(word), {req, " tdata"}, tdata, swap(word));
    check(tkeep == meta[NB-1:0], {req, " tkeep"}, tkeep, meta[NB-1:0]);
    check(tlast == meta[15], {req, " tlast"}, tlast, meta[15]);
    check(tuser == meta[31:16], {req, " tuser"}, tuser, meta[31:16]);
    tready = 1;
    @(posedge clk); #1;
    tready = 0;
  endtask

  // R10 reset state
  task automatic t_reset();
    @(negedge clk);
    check(tvalid == 0, "R10 tvalid after reset", tvalid, 0);
    check(frame_len == 0, "R10 frame_len after reset", frame_len, 0);
    check(wr_ready == 1, "R7 ready when empty", wr_ready, 1);
  endtask

  // R1 R2 length register
  task automatic t_length();
    wr(8'h10, 32'hABCD_003C);
    @(negedge clk);
    check(frame_len == 16'h003C, "R2 length latch", frame_len, 16'h003C);
    check(tvalid == 0, "R1 length write makes no beat", tvalid, 0);
  endtask

  // R3 R4 R5 R6 basic frame
  task automatic t_frame();
    wr(8'h08, 32'h0002_000F);
    @(negedge clk);
    check(tvalid == 0, "R1 meta write makes no beat", tvalid, 0);
    wr(8'h00, 32'h1122_3344);
    check(tvalid == 1, "R3 beat valid after data write", tvalid, 1);
    pop_check("R4 R5 first beat", 32'h1122_3344, 32'h0002_000F);
    wr(8'h00, 32'h5566_7788);
    pop_check("R6 meta persists", 32'h5566_7788, 32'h0002_000F);
    wr(8'h08, 32'h0102_8003);
    wr(8'h00, 32'hAABB_0000);
    pop_check("R5 final beat", 32'hAABB_0000, 32'h0102_8003);
    @(negedge clk);
    check(tvalid == 0, "R3 exactly one beat per write", tvalid, 0);
  endtask

  // R9 unmapped addresses
  task automatic t_ignore();
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_1234);
    wr(8'h88, 32'h0000_5678);
    @(negedge clk);
    check(tvalid == 0, "R9 no beat from unmapped write", tvalid, 0);
    check(frame_len == 16'h003C, "R9 length untouched", frame_len, 16'h003C);
    wr(8'h00, 32'hCAFE_F00D);
    pop_check("R9 meta untouched", 32'hCAFE_F00D, 32'h0102_8003);
  endtask

  // R7 R8 backpressure
  task automatic t_full();
    logic [DW-1:0] held;
    wr(8'h08, 32'h0004_000F);
    for (int i = 0; i < DEPTH; i++) wr(8'h00, 32'h1000_0000 + i);
    @(negedge clk);
    held = tdata;
    check(tvalid == 1, "R8 valid while stalled", tvalid, 1);
    @(negedge clk);
    check(tdata == held && held == swap(32'h1000_0000), "R8 data held while stalled", tdata, swap(32'h1000_0000));
    wr(8'h10, 32'h0000_0040);
    wr(8'h08, 32'h0008_800F);
    @(negedge clk);
    check(frame_len == 16'h0040, "R7 length write accepted while full", frame_len, 16'h0040);
    fork wr(8'h00, 32'h2000_0004); join_none
    @(negedge clk); #2;
    check(wr_ready == 0, "R7 data write stalled when full", wr_ready, 0);
    repeat (2) @(negedge clk);
    #2;
    check(wr_ready == 0, "R7 still stalled", wr_ready, 0);
    for (int i = 0; i < DEPTH; i++) pop_check("R7 R8 in-order drain", 32'h1000_0000 + i, 32'h0004_000F);
    pop_check("R7 stalled write not lost", 32'h2000_0004, 32'h0008_800F);
    @(negedge clk);
    check(tvalid == 0, "R7 drained", tvalid, 0);
  endtask

  // R6 R10 reset mid-traffic
  task automatic t_reset_mid();
    wr(8'h08, 32'h0010_800F);
    wr(8'h00, 32'h0BAD_0BAD);
    wr(8'h00, 32'h0BAD_0BAD);
    @(negedge clk);
    rst_ni = 0;
    #3;
    check(tvalid == 0, "R10 FIFO emptied", tvalid, 0);
    check(frame_len == 0, "R10 length cleared", frame_len, 0);
    @(negedge clk);
    rst_ni = 1;
    wr(8'h00, 32'h0102_0304);
    pop_check("R6 meta cleared by reset", 32'h0102_0304, 32'h0000_0000);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    wr_addr = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_length();
    t_frame();
    t_ignore();
    t_full();
    t_reset_mid();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule